// File: doc/BRIEF.md
# Host controller interrupt status and done-queue delay

This block holds the interrupt side of a USB host controller: a status register of latched event bits, an enable mask with a master enable in its top bit, and a level interrupt line. Other logic signals events as one-cycle pulses on a 32-bit vector. Software clears status bits by writing ones. It adds mask bits through an enable port and removes them through a disable port.

The block also holds the delay that decides when the queue of finished transfers is handed back to software. Each retired transfer carries a small delay request, in frames. The block keeps the smallest request still pending and counts it down on frame boundaries. When the count reaches zero, and the previous writeback has been acknowledged, the block pulses a writeback request. The request carries a flag that tells the memory side whether another enabled interrupt is already pending.

Top module: `hc_irq_ctrl`

## Requirements
- R1: After reset the status reads 0 and the mask reads 0x80000000. The interrupt line is low and the delay counter is idle at 7, so frame ticks alone never request a writeback.
- R2: `irq_o` is high exactly when mask bit 31 is set and the bitwise AND of status and mask is nonzero.
- R3: A write with select 0 clears every status bit written as 1 and leaves the other status bits alone.
- R4: A write with select 1 ORs the data into the mask and a write with select 2 clears the mask bits written as 1. Reads with select 1 and select 2 both return the mask, select 0 returns the status and select 3 returns 0.
- R5: Only bits 0 to 6 and 30 exist in the status, and the mask has those bits plus bit 31. All other bits read 0 whatever is written or signalled.
- R6: A retire pulse sets the delay counter to the smaller of its value and the 3-bit delay request.
- R7: A frame tick that sees the counter at 0 and status bit 1 clear raises `wb_fire_o` for exactly the following cycle. In that same cycle status bit 1 reads set and the counter reloads to 7.
- R8: While status bit 1 is set, no writeback is requested and a counter at 0 stays at 0.
- R9: `wb_pend_o`, valid with `wb_fire_o`, is 1 when status AND mask was nonzero at the tick that caused the writeback.
- R10: After the writeback check, each frame tick lowers the counter by one unless it is 7 or 0. A delay request of 3 therefore fires on the fourth tick.
- R11: An event pulse in the same cycle as a status write that clears the same bit leaves the bit set.
- R12: A retire and a frame tick in the same cycle apply the tick first, then the minimum with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 status, 1 enable, 2 disable |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read select: 0 status, 1 or 2 mask, 3 zero |
| rd_data_o | output | 32 | Read data |
| evt_set_i | input | 32 | Event pulses, one per status bit |
| frame_tick_i | input | 1 | Frame boundary pulse |
| retire_i | input | 1 | Transfer retired pulse |
| retire_dly_i | input | 3 | Requested writeback delay in frames |
| wb_fire_o | output | 1 | Writeback request pulse |
| wb_pend_o | output | 1 | Enabled interrupt pending at writeback |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench builds the block with its default 3-bit delay field, so the idle value is 7 and every request from 0 to 6 can be driven. This keeps the whole countdown observable in a few ticks. The parts exercised include the full countdown, a writeback held back by an unacknowledged earlier writeback, the minimum taken over several requests, and a retire landing on the same cycle as a tick. The 32-bit registers make the unimplemented-bit masking visible from the read port.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned BIT_WB  = 1;
  localparam int unsigned BIT_MIE = 31;
  localparam logic [REG_W-1:0] STAT_IMPL = 32'h4000_007F;
  localparam logic [REG_W-1:0] MASK_IMPL = 32'hC000_007F;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_ENA  = 2'd1,
    SEL_DIS  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/hc_irq_regs.sv
module hc_irq_regs
  import hc_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic [REG_W-1:0] evt_set_i,
  input  logic             wb_set_i,
  output logic [REG_W-1:0] stat_o,
  output logic [REG_W-1:0] mask_o
);
  logic [REG_W-1:0] stat_q, stat_d, mask_q, mask_d, clr_v, set_v;
  logic             stat_en, mask_en;

  always_comb begin
    clr_v = (wr_en_i && wr_sel_i == SEL_STAT) ? wr_data_i : '0;
    set_v = evt_set_i;
    set_v[BIT_WB] = set_v[BIT_WB] | wb_set_i;
    // events win over a clearing write in the same cycle
    stat_d  = ((stat_q & ~clr_v) | set_v) & STAT_IMPL;
    stat_en = (wr_en_i && wr_sel_i == SEL_STAT) || (|evt_set_i) || wb_set_i;
    mask_d  = mask_q;
    mask_en = 1'b0;
    if (wr_en_i && wr_sel_i == SEL_ENA) begin
      mask_d  = (mask_q | wr_data_i) & MASK_IMPL;
      mask_en = 1'b1;
    end else if (wr_en_i && wr_sel_i == SEL_DIS) begin
      mask_d  = mask_q & ~wr_data_i;
      mask_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= REG_W'(1) << BIT_MIE;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/hc_done_delay.sv
module hc_done_delay #(
  parameter int unsigned DLY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_tick_i,
  input  logic             retire_i,
  input  logic [DLY_W-1:0] retire_dly_i,
  input  logic             wb_busy_i,
  input  logic             pend_now_i,
  output logic             fire_now_o,
  output logic             fire_o,
  output logic             pend_o
);
  localparam logic [DLY_W-1:0] IDLE = {DLY_W{1'b1}};

  logic [DLY_W-1:0] cnt_q, cnt_d, cnt_tick;
  logic             fire_q, pend_q, fire_now;

  always_comb begin
    fire_now = frame_tick_i && (cnt_q == '0) && !wb_busy_i;
    cnt_tick = cnt_q;
    if (fire_now)
      cnt_tick = IDLE;
    else if (frame_tick_i && cnt_q != IDLE && cnt_q != '0)
      cnt_tick = cnt_q - 1'b1;
    cnt_d = cnt_tick;
    if (retire_i && retire_dly_i < cnt_tick)
      cnt_d = retire_dly_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= IDLE;
      fire_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (frame_tick_i || retire_i) cnt_q <= cnt_d;
      fire_q <= fire_now;
      pend_q <= fire_now && pend_now_i;
    end
  end

  assign fire_now_o = fire_now;
  assign fire_o     = fire_q;
  assign pend_o     = pend_q;
endmodule

// File: rtl/hc_irq_out.sv
module hc_irq_out
  import hc_irq_pkg::*;
(
  input  logic [REG_W-1:0] stat_i,
  input  logic [REG_W-1:0] mask_i,
  output logic             pend_o,
  output logic             irq_o
);
  logic [REG_W-1:0] hit;
  always_comb begin
    hit    = stat_i & mask_i;
    pend_o = |hit;
    irq_o  = mask_i[BIT_MIE] && pend_o;
  end
endmodule

// File: rtl/hc_irq_ctrl.sv
module hc_irq_ctrl
  import hc_irq_pkg::*;
#(
  parameter int unsigned DLY_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [31:0]      wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [31:0]      rd_data_o,
  input  logic [31:0]      evt_set_i,
  input  logic             frame_tick_i,
  input  logic             retire_i,
  input  logic [DLY_W-1:0] retire_dly_i,
  output logic             wb_fire_o,
  output logic             wb_pend_o,
  output logic             irq_o
);
  logic [REG_W-1:0] stat_q, mask_q;
  logic             fire_now, pend_any;

  hc_irq_regs i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .evt_set_i (evt_set_i),
    .wb_set_i  (fire_now),
    .stat_o    (stat_q),
    .mask_o    (mask_q)
  );

  hc_done_delay #(.DLY_W(DLY_W)) i_delay (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_tick_i (frame_tick_i),
    .retire_i     (retire_i),
    .retire_dly_i (retire_dly_i),
    .wb_busy_i    (stat_q[BIT_WB]),
    .pend_now_i   (pend_any),
    .fire_now_o   (fire_now),
    .fire_o       (wb_fire_o),
    .pend_o       (wb_pend_o)
  );

  hc_irq_out i_out (
    .stat_i (stat_q),
    .mask_i (mask_q),
    .pend_o (pend_any),
    .irq_o  (irq_o)
  );

  always_comb begin
    case (rd_sel_i)
      SEL_STAT:         rd_data_o = stat_q;
      SEL_ENA, SEL_DIS: rd_data_o = mask_q;
      default:          rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/hc_irq_chk.sv
module hc_irq_chk
  import hc_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [REG_W-1:0] evt_set_i,
  input logic             frame_tick_i,
  input logic             wb_fire_o,
  input logic             irq_o,
  input logic [REG_W-1:0] stat_q,
  input logic [REG_W-1:0] mask_q
);
  AST_IRQ_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q[BIT_MIE] && |(stat_q & mask_q))); // R2
  AST_FIRE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_fire_o |-> $past(frame_tick_i)); // R7
  AST_FIRE_SETS_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_fire_o |-> stat_q[BIT_WB]); // R7
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_fire_o |=> !wb_fire_o); // R8
  AST_EVENT_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_set_i & STAT_IMPL)) |=>
      ((stat_q & $past(evt_set_i) & STAT_IMPL) == ($past(evt_set_i) & STAT_IMPL))); // R11
endmodule

bind hc_irq_ctrl hc_irq_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .evt_set_i    (evt_set_i),
  .frame_tick_i (frame_tick_i),
  .wb_fire_o    (wb_fire_o),
  .irq_o        (irq_o),
  .stat_q       (stat_q),
  .mask_q       (mask_q)
);

// File: tb/test_hc_irq_ctrl.sv
`timescale 1ns/1ps
module test_hc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [31:0] evt = '0;
  logic        tick = 1'b0;
  logic        ret = 1'b0;
  logic [2:0]  ret_dly = '0;
  logic        fire, pend, irq;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  hc_irq_ctrl i_hc_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .evt_set_i(evt), .frame_tick_i(tick), .retire_i(ret),
    .retire_dly_i(ret_dly), .wb_fire_o(fire), .wb_pend_o(pend), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [31:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic retire(input logic [2:0] d);
    ret = 1'b1; ret_dly = d;
    @(negedge clk);
    ret = 1'b0;
  endtask

  // one frame tick; returns the writeback pulse seen in the next cycle
  task automatic frame(output logic f, output logic p);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    f = fire; p = pend;
  endtask

  task automatic t_reset;
    logic [31:0] v; logic f, p;
    rd(2'd0, v); chk("R1 status", v, 32'h0);
    rd(2'd1, v); chk("R1 mask", v, 32'h8000_0000);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      frame(f, p); chk("R1 idle counter no fire", {31'd0, f}, 32'd0);
    end
  endtask

  task automatic t_irq;
    logic [31:0] v;
    pulse_evt(32'h4);
    rd(2'd0, v); chk("R2 status after event", v, 32'h4);
    chk("R2 masked off irq", {31'd0, irq}, 32'd0);
    wr(2'd1, 32'h4);
    chk("R2 irq enabled", {31'd0, irq}, 32'd1);
    rd(2'd2, v); chk("R4 mask via disable select", v, 32'h8000_0004);
    rd(2'd3, v); chk("R4 select 3 reads zero", v, 32'h0);
    wr(2'd2, 32'h8000_0000);
    chk("R2 master off", {31'd0, irq}, 32'd0);
    wr(2'd1, 32'h8000_0000);
    chk("R2 master back on", {31'd0, irq}, 32'd1);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(2'd0, 32'h4);
    rd(2'd0, v); chk("R3 cleared", v, 32'h0);
    chk("R3 irq low", {31'd0, irq}, 32'd0);
    pulse_evt(32'h0000_0030);
    wr(2'd0, 32'h0000_0010);
    rd(2'd0, v); chk("R3 partial clear", v, 32'h0000_0020);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R5 mask bits", v, 32'hC000_007F);
    pulse_evt(32'hFFFF_FFFF);
    rd(2'd0, v); chk("R5 status bits", v, 32'h4000_007F);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd2, 32'h7FFF_FFFF);
    rd(2'd1, v); chk("R4 disable clears", v, 32'h8000_0000);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    evt = 32'h8; wr_en = 1'b1; wr_sel = 2'd0; wr_data = 32'h8;
    @(negedge clk);
    evt = '0; wr_en = 1'b0;
    rd(2'd0, v); chk("R11 event beats clear", v, 32'h8);
    wr(2'd0, 32'h8);
  endtask

  task automatic t_delay;
    logic [31:0] v; logic f, p;
    retire(3'd3);
    for (int i = 0; i < 3; i++) begin
      frame(f, p); chk("R10 no fire during countdown", {31'd0, f}, 32'd0);
    end
    frame(f, p);
    chk("R10 fire on fourth tick", {31'd0, f}, 32'd1);
    chk("R9 nothing pending", {31'd0, p}, 32'd0);
    rd(2'd0, v); chk("R7 writeback bit set", v, 32'h2);
    @(negedge clk);
    chk("R7 single pulse", {31'd0, fire}, 32'd0);
    wr(2'd0, 32'h2);
    for (int i = 0; i < 2; i++) begin
      frame(f, p); chk("R7 counter reloaded", {31'd0, f}, 32'd0);
    end
  endtask

  task automatic t_block;
    logic [31:0] v; logic f, p;
    pulse_evt(32'h2);
    retire(3'd0);
    for (int i = 0; i < 2; i++) begin
      frame(f, p); chk("R8 held while unacknowledged", {31'd0, f}, 32'd0);
    end
    wr(2'd1, 32'h1);
    pulse_evt(32'h1);
    wr(2'd0, 32'h2);
    frame(f, p);
    chk("R8 fires after acknowledge", {31'd0, f}, 32'd1);
    chk("R9 pending flag", {31'd0, p}, 32'd1);
    rd(2'd0, v); chk("R7 status", v, 32'h3);
    wr(2'd0, 32'h3);
    wr(2'd2, 32'h1);
  endtask

  task automatic t_min;
    logic f, p;
    retire(3'd5);
    retire(3'd6);
    retire(3'd2);
    retire(3'd4);
    for (int i = 0; i < 2; i++) begin
      frame(f, p); chk("R6 min held", {31'd0, f}, 32'd0);
    end
    frame(f, p); chk("R6 min of requests", {31'd0, f}, 32'd1);
    wr(2'd0, 32'h2);
  endtask

  task automatic t_same;
    logic f, p;
    tick = 1'b1; ret = 1'b1; ret_dly = 3'd1;
    @(negedge clk);
    tick = 1'b0; ret = 1'b0;
    chk("R12 no fire on combined cycle", {31'd0, fire}, 32'd0);
    frame(f, p); chk("R12 counts from request", {31'd0, f}, 32'd0);
    frame(f, p); chk("R12 fires second tick", {31'd0, f}, 32'd1);
    wr(2'd0, 32'h2);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq();
    t_clear();
    t_collide();
    t_delay();
    t_block();
    t_min();
    t_same();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule